// File: doc/BRIEF.md
# Dual-Channel Serial Command Register Bank

This block is the digital front end of a two-channel converter. A host shifts a 16-bit command word in over a three-wire serial link (serial clock, serial data, and an active-low select/load strobe). The serial pins are sampled in the system clock domain. When the select/load strobe returns high, the block decodes the word's 4-bit opcode and acts on it.

Each channel has two register levels: a staging register that receives new codes, and an output register that drives the converter. Opcodes can stage a code, move both staged codes into both output registers at once, wake the block, or put it to sleep, and some opcodes do several of these together. Staging is allowed while asleep, so a single command can later wake the block and present fresh values on both channels together.

Top module: `dual_dac_cmd_bank`

## Requirements
- R1: A frame is 16 bits, each field MSB first: a 4-bit opcode, then a 10-bit code, then two pad bits whose values are ignored.
- R2: Serial data is captured on rising edges of sck_i only while sel_ld_i is low. Edges of sck_i while sel_ld_i is high leave the capture window unchanged.
- R3: The opcode acts on a rising edge of sel_ld_i, using the last 16 bits captured. Register outputs change on the third system clock edge after sel_ld_i rises and at no other time. Extra leading bits in a frame are discarded.
- R4: Opcode 0000 does nothing. Opcode 0001 stages the code for channel A and opcode 0010 stages it for channel B. None of these three changes code_a_o, code_b_o or the power state.
- R5: Opcode 1000 copies both staging registers into both output registers and sets awake_o.
- R6: Opcode 1001 (channel A) or 1010 (channel B) stages the new code for that channel, then updates both outputs from the staging registers and sets awake_o.
- R7: Opcode 1111 stages the same code on both channels, updates both outputs and sets awake_o.
- R8: Opcode 1101 only wakes the block. Opcode 1110 only puts it to sleep and ignores the code field. out_hiz_o is high exactly while the block is asleep.
- R9: Opcodes 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change no staging register, output register or power state.
- R10: After reset, all staging and output registers are zero, awake_o is 1 and out_hiz_o is 0.
- R11: Staging a code while asleep does not wake the block. All register contents are retained through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data (asynchronous) |
| sel_ld_i | input | 1 | Select, active low; its rising edge executes the frame |
| code_a_o | output | 10 | Output register, channel A |
| code_b_o | output | 10 | Output register, channel B |
| awake_o | output | 1 | Block is awake |
| out_hiz_o | output | 1 | Analog outputs should be high impedance |

## Verification
The assertions check on every cycle that the capture window moves only on a qualified serial clock edge, and that the outputs and the power state hold still except on an execute strobe. They also check the per-opcode effects that are visible one cycle after execution: sleep, wake, broadcast equality, and the quiet opcodes. Only the directed scenarios can show that the staging registers held the right value. That needs a later update opcode, as after loads made while asleep or after reserved codes. The scenarios also cover the three-edge latency from the strobe, discarding of surplus leading bits, and the bit order of the frame fields.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NOP        = 4'b0000,
    OP_LD_A       = 4'b0001,
    OP_LD_B       = 4'b0010,
    OP_UPD        = 4'b1000,
    OP_LD_A_UPD   = 4'b1001,
    OP_LD_B_UPD   = 4'b1010,
    OP_WAKE       = 4'b1101,
    OP_SLEEP      = 4'b1110,
    OP_LD_ALL_UPD = 4'b1111
  } opcode_e;

  typedef struct packed {
    logic load_a;
    logic load_b;
    logic update;
    logic wake;
    logic sleep;
  } cmd_act_t;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int             STAGES  = 2,
  parameter int             WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dac_cmd_shifter.sv
module dac_cmd_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
  end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output cmd_act_t          act_o
);
  always_comb begin
    act_o = '0;
    case (ctrl_i)
      OP_LD_A:       act_o.load_a = 1'b1;
      OP_LD_B:       act_o.load_b = 1'b1;
      OP_UPD:        begin act_o.update = 1'b1; act_o.wake = 1'b1; end
      OP_LD_A_UPD:   begin act_o.load_a = 1'b1; act_o.update = 1'b1; act_o.wake = 1'b1; end
      OP_LD_B_UPD:   begin act_o.load_b = 1'b1; act_o.update = 1'b1; act_o.wake = 1'b1; end
      OP_LD_ALL_UPD: begin
        act_o.load_a = 1'b1; act_o.load_b = 1'b1;
        act_o.update = 1'b1; act_o.wake   = 1'b1;
      end
      OP_WAKE:       act_o.wake  = 1'b1;
      OP_SLEEP:      act_o.sleep = 1'b1;
      default:       act_o = '0; // no-op and reserved codes
    endcase
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              update_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o
);
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] stage_d;

  // update sees the code staged by the same command
  assign stage_d = load_i ? data_i : stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      dac_o   <= '0;
    end else begin
      stage_q <= stage_d;
      if (update_i) dac_o <= stage_d;
    end
  end
endmodule

// File: rtl/dual_dac_cmd_bank.sv
module dual_dac_cmd_bank
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int CTRL_W      = 4,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              sel_ld_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic              awake_o,
  output logic              out_hiz_o
);
  localparam int WORD_W = CTRL_W + DATA_W + PAD_W;
  localparam int N_CH   = 2;
  localparam int I_SCK  = 0;
  localparam int I_SDI  = 1;
  localparam int I_SEL  = 2;

  logic [2:0]        pin_q, pin_rise;
  logic              shift, exec;
  logic [WORD_W-1:0] window;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] data;
  cmd_act_t          act;
  logic [N_CH-1:0]   ch_load;
  logic [DATA_W-1:0] ch_code [N_CH];
  logic              awake_q;

  dac_in_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_ld_i, sdi_i, sck_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise)
  );

  assign shift = pin_rise[I_SCK] & ~pin_q[I_SEL];
  assign exec  = pin_rise[I_SEL];

  dac_cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .bit_i  (pin_q[I_SDI]),
    .word_o (window)
  );

  assign ctrl = window[WORD_W-1 -: CTRL_W];
  assign data = window[PAD_W +: DATA_W];

  dac_cmd_decode #(.CTRL_W(CTRL_W)) u_dec (
    .ctrl_i(ctrl),
    .act_o (act)
  );

  assign ch_load = {act.load_b, act.load_a};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    dac_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (exec & ch_load[ch]),
      .update_i(exec & act.update),
      .data_i  (data),
      .dac_o   (ch_code[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                awake_q <= 1'b1;
    else if (exec & act.wake)   awake_q <= 1'b1;
    else if (exec & act.sleep)  awake_q <= 1'b0;
  end

  assign code_a_o  = ch_code[0];
  assign code_b_o  = ch_code[1];
  assign awake_o   = awake_q;
  assign out_hiz_o = ~awake_q;
endmodule

// File: rtl/dual_dac_cmd_bank_chk.sv
module dual_dac_cmd_bank_chk #(
  parameter int DATA_W = 10,
  parameter int WORD_W = 16,
  parameter int CTRL_W = 4,
  parameter int PAD_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic              shift_i,
  input logic [WORD_W-1:0] window_i,
  input logic [DATA_W-1:0] code_a_i,
  input logic [DATA_W-1:0] code_b_i,
  input logic              awake_i,
  input logic              hiz_i
);
  logic [CTRL_W-1:0] op;
  logic [DATA_W-1:0] fld;
  logic              op_quiet, op_rsvd, op_wakes;

  assign op       = window_i[WORD_W-1 -: CTRL_W];
  assign fld      = window_i[PAD_W +: DATA_W];
  assign op_quiet = (op == 4'h0) || (op == 4'h1) || (op == 4'h2);
  assign op_rsvd  = (op inside {4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'hC});
  assign op_wakes = (op inside {4'h8, 4'h9, 4'hA, 4'hD, 4'hF});

  AST_WINDOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(window_i)); // R2
  AST_QUIET_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(code_a_i) && $stable(code_b_i) && $stable(awake_i)); // R3
  AST_STAGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_quiet |=> $stable(code_a_i) && $stable(code_b_i) && $stable(awake_i)); // R4
  AST_WAKE_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_wakes |=> awake_i && !hiz_i); // R5
  AST_BCAST_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op == 4'hF |=> code_a_i == code_b_i && code_a_i == $past(fld)); // R7
  AST_SLEEP_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op == 4'hE |=> !awake_i && hiz_i && $stable(code_a_i) && $stable(code_b_i)); // R8
  AST_RSVD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_rsvd |=> $stable(code_a_i) && $stable(code_b_i) && $stable(awake_i)); // R9
endmodule

bind dual_dac_cmd_bank dual_dac_cmd_bank_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W), .PAD_W(PAD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec),
  .shift_i (shift),
  .window_i(window),
  .code_a_i(code_a_o),
  .code_b_i(code_b_o),
  .awake_i (awake_o),
  .hiz_i   (out_hiz_o)
);

// File: tb/dual_dac_cmd_bank_tb.sv
module dual_dac_cmd_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, sdi = 1'b0, sel = 1'b1;
  logic [9:0] code_a, code_b;
  logic       awake, hiz;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_cmd_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .sel_ld_i(sel),
    .code_a_o(code_a), .code_b_o(code_b), .awake_o(awake), .out_hiz_o(hiz)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [9:0] ea, input logic [9:0] eb, input logic ew);
    chk(req, {22'd0, code_a}, {22'd0, ea});
    chk(req, {22'd0, code_b}, {22'd0, eb});
    chk(req, {31'd0, awake}, {31'd0, ew});
    chk(req, {31'd0, hiz}, {31'd0, ~ew});
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
    tick(4);
  endtask

  task automatic frame_body(input logic [3:0] op, input logic [9:0] d);
    sel = 1'b0;
    tick(4);
    shift_bits({16'd0, op, d, 2'b11}, 16);
  endtask

  task automatic frame(input logic [3:0] op, input logic [9:0] d);
    frame_body(op, d);
    sel = 1'b1;
    tick(8);
  endtask

  task automatic t_reset;
    chk_state("R10 reset", 10'h000, 10'h000, 1'b1);
  endtask

  task automatic t_stage_then_update;
    frame(4'b0001, 10'h155);
    chk_state("R4 stage A", 10'h000, 10'h000, 1'b1);
    frame(4'b0010, 10'h2AA);
    chk_state("R4 stage B", 10'h000, 10'h000, 1'b1);
    frame(4'b0000, 10'h3FF);
    chk_state("R4 nop", 10'h000, 10'h000, 1'b1);
    frame(4'b1000, 10'h3FF);
    chk_state("R5 R1 update both", 10'h155, 10'h2AA, 1'b1);
  endtask

  task automatic t_single_update;
    frame(4'b1001, 10'h0F0);
    chk_state("R6 load A update", 10'h0F0, 10'h2AA, 1'b1);
    frame(4'b1010, 10'h00F);
    chk_state("R6 load B update", 10'h0F0, 10'h00F, 1'b1);
  endtask

  task automatic t_broadcast_latency;
    frame_body(4'b1111, 10'h3C3);
    sel = 1'b1;
    tick(2);
    chk_state("R3 before third edge", 10'h0F0, 10'h00F, 1'b1);
    tick(1);
    chk_state("R3 R7 after third edge", 10'h3C3, 10'h3C3, 1'b1);
    tick(5);
  endtask

  task automatic t_sleep_cycle;
    frame(4'b1110, 10'h123);
    chk_state("R8 sleep", 10'h3C3, 10'h3C3, 1'b0);
    frame(4'b0001, 10'h011);
    chk_state("R11 stage asleep", 10'h3C3, 10'h3C3, 1'b0);
    frame(4'b1101, 10'h2F2);
    chk_state("R8 wake only", 10'h3C3, 10'h3C3, 1'b1);
    frame(4'b1000, 10'h000);
    chk_state("R11 staged kept", 10'h011, 10'h3C3, 1'b1);
  endtask

  task automatic t_reserved;
    logic [3:0] rsvd [7] = '{4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'hC};
    frame(4'b1110, 10'h000);
    for (int i = 0; i < 7; i++) begin
      frame(rsvd[i], 10'h3FF);
      chk_state("R9 reserved", 10'h011, 10'h3C3, 1'b0);
    end
    frame(4'b1000, 10'h000);
    chk_state("R9 staging intact", 10'h011, 10'h3C3, 1'b1);
  endtask

  task automatic t_sck_while_high;
    frame(4'b1001, 10'h055);
    chk_state("R2 setup", 10'h055, 10'h3C3, 1'b1);
    sdi = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(4);
    sel = 1'b0;
    tick(6);
    sel = 1'b1;
    tick(8);
    chk_state("R2 sck ignored when high", 10'h055, 10'h3C3, 1'b1);
  endtask

  task automatic t_overlength;
    sel = 1'b0;
    tick(4);
    shift_bits({12'd0, 4'b1111, 4'b1010, 10'h1A5, 2'b00}, 20);
    sel = 1'b1;
    tick(8);
    chk_state("R3 last 16 bits", 10'h055, 10'h1A5, 1'b1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_stage_then_update();
    t_single_update();
    t_broadcast_latency();
    t_sleep_cycle();
    t_reserved();
    t_sck_while_high();
    t_overlength();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule